// File: doc/BRIEF.md
# Three-Digit Combination Lock Controller

This block checks a secret code entered one 4-bit digit at a time. Three code registers hold the secret. Each register has its own write strobe and shares a common value input. The user presents a digit on `digitIn` and marks it with a one-cycle `digitValid` pulse. A small controller walks through three entry positions. At each position, a multiplexer steered by the present state picks the matching code register, and a comparator checks it against the entered digit.

A match moves the controller to the next position, and after the third match it reaches the unlocked state. A mismatch at any position sends it to a fault state. The fault state swallows every later digit until reset. The unlocked state also ignores further digits. Reset is synchronous and beats every other input in the same cycle. It returns the controller to the first position but leaves the stored code untouched. The only output is a registered open flag, which is high in the unlocked state alone.

Top module: `lock_combo`

## Requirements
- R1: A high `rst` at a rising edge puts the controller back at the first entry position with `isOpen` low, whatever `digitValid` and `digitIn` carry in that cycle.
- R2: Three strobed digits equal to code registers 0, 1 and 2, in that order, raise `isOpen` at the same rising edge that captures the third strobe.
- R3: A cycle with `digitValid` low leaves the controller where it is, so idle gaps of any length may sit between digits.
- R4: A strobed digit that differs from the code register selected for the current position moves the controller to the fault state with `isOpen` low.
- R5: In the fault state every strobe is ignored, including a fully correct code sequence, so `isOpen` stays low until `rst` returns the controller to the first position.
- R6: Once unlocked, `isOpen` stays high through any further strobes, right or wrong, until `rst`.
- R7: A high `loadCode[i]` at a rising edge writes `codeIn` into code register i. The register keeps its value otherwise, and `rst` does not clear it.
- R8: The digit at entry position k (counting from 0) is compared only with code register k. A digit that equals a different register's value counts as a mismatch.
- R9: `isOpen` is a registered output. It is low in every state except the unlocked one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadCode | input | 3 | Write strobe per code register, bit i writes register i |
| codeIn | input | 4 | Value written into a code register |
| digitIn | input | 4 | Digit currently presented |
| digitValid | input | 1 | One-cycle strobe marking a new digit |
| isOpen | output | 1 | High while the lock is open |

## Verification
The assertions take all inputs to be synchronous to `clk`, so keypad scanning, debouncing and synchronisation have already happened upstream. Each strobe is taken as exactly one digit, and the registers' contents before their first load are treated as undefined. The stimulus changes inputs only at falling edges. It writes all three code registers before the first digit is entered. In the random phase, most digits are biased toward the value the current position expects, so complete openings happen often, and occasional resets and code reloads mix in among them.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int DIGIT_W  = 4;
  localparam int CODE_LEN = 3;
  localparam int SEL_W    = $clog2(CODE_LEN);

  typedef enum logic [2:0] {
    ST_POS0  = 3'd0,
    ST_POS1  = 3'd1,
    ST_POS2  = 3'd2,
    ST_OPEN  = 3'd3,
    ST_FAULT = 3'd4
  } lockState_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             cmpEn;
  } lockCtrl_t;
endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int DW = DIGIT_W,
  parameter int NC = CODE_LEN,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] loadCode,
  input  logic [DW-1:0] codeIn,
  input  logic [DW-1:0] digitIn,
  input  lockCtrl_t     ctrl,
  output logic          digitMatch
);
  logic [DW-1:0] codeQ [NC];
  logic [DW-1:0] codeSel;

  for (genvar g = 0; g < NC; g++) begin : gCode
    always_ff @(posedge clk) begin
      if (loadCode[g]) codeQ[g] <= codeIn;
    end

    // R7: a strobed write lands; an unstrobed register holds
    a_r7_load_lands: assert property (@(posedge clk) disable iff (rst)
      loadCode[g] |=> codeQ[g] == $past(codeIn));
    a_r7_hold_unloaded: assert property (@(posedge clk)
      !loadCode[g] |=> $stable(codeQ[g]));
  end

  always_comb begin
    codeSel = '0;
    for (int i = 0; i < NC; i++) begin
      if (ctrl.sel == i[SW-1:0]) codeSel = codeQ[i];
    end
  end

  assign digitMatch = (digitIn == codeSel);
endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      digitValid,
  input  logic      digitMatch,
  output lockCtrl_t ctrl,
  output logic      openQ
);
  lockState_t state, stateNext;
  logic inEntry;

  assign inEntry = (state == ST_POS0) || (state == ST_POS1) || (state == ST_POS2);

  always_comb begin
    ctrl.cmpEn = inEntry && digitValid;
    unique case (state)
      ST_POS1: ctrl.sel = SEL_W'(1);
      ST_POS2: ctrl.sel = SEL_W'(2);
      default: ctrl.sel = SEL_W'(0);
    endcase
  end

  always_comb begin
    stateNext = state;
    if (ctrl.cmpEn) begin
      if (!digitMatch) begin
        stateNext = ST_FAULT;
      end else begin
        unique case (state)
          ST_POS0: stateNext = ST_POS1;
          ST_POS1: stateNext = ST_POS2;
          default: stateNext = ST_OPEN;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_POS0;
      openQ <= 1'b0;
    end else begin
      state <= stateNext;
      openQ <= (stateNext == ST_OPEN);
    end
  end

  // R1: reset wins over a simultaneous strobe
  a_r1_reset_home: assert property (@(posedge clk)
    rst |=> (state == ST_POS0) && !openQ);
  // R3: no strobe, no move
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !digitValid |=> $stable(state));
  // R4: mismatch in an entry position leads to fault
  a_r4_mismatch_faults: assert property (@(posedge clk) disable iff (rst)
    (inEntry && digitValid && !digitMatch) |=> state == ST_FAULT);
  // R5: fault absorbs
  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT) |=> (state == ST_FAULT) && !openQ);
  // R6: open absorbs
  a_r6_open_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPEN) |=> (state == ST_OPEN) && openQ);
endmodule

// File: rtl/lock_combo.sv
module lock_combo
  import lock_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CODE_LEN-1:0] loadCode,
  input  logic [DIGIT_W-1:0]  codeIn,
  input  logic [DIGIT_W-1:0]  digitIn,
  input  logic                digitValid,
  output logic                isOpen
);
  lockCtrl_t ctrl;
  logic digitMatch;

  lock_datapath uDatapath (
    .clk        (clk),
    .rst        (rst),
    .loadCode   (loadCode),
    .codeIn     (codeIn),
    .digitIn    (digitIn),
    .ctrl       (ctrl),
    .digitMatch (digitMatch)
  );

  lock_control uControl (
    .clk        (clk),
    .rst        (rst),
    .digitValid (digitValid),
    .digitMatch (digitMatch),
    .ctrl       (ctrl),
    .openQ      (isOpen)
  );

  // R2: the lock only opens on a strobed digit
  a_r2_open_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(isOpen) |-> $past(digitValid));
  // R9: output falls only through reset
  a_r9_no_silent_close: assert property (@(posedge clk) disable iff (rst)
    $fell(isOpen) |-> $past(rst));
endmodule

// File: tb/lock_combo_test.sv
`timescale 1ns/1ps
module lock_combo_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] loadCode;
  logic [3:0] codeIn;
  logic [3:0] digitIn;
  logic       digitValid;
  logic       isOpen;

  int nChecks = 0;
  int nFails  = 0;
  int expState = 0;        // 0..2 entry position, 3 open, 4 fault
  logic [3:0] expCode [3];
  bit done = 0;

  always #2.5 clk = ~clk;

  lock_combo uut (
    .clk(clk), .rst(rst), .loadCode(loadCode), .codeIn(codeIn),
    .digitIn(digitIn), .digitValid(digitValid), .isOpen(isOpen)
  );

  function automatic int modelNext(int s, bit r, bit v, logic [3:0] d, logic [3:0] c);
    if (r) return 0;
    if (s < 3 && v) return (d == c) ? s + 1 : 4;
    return s;
  endfunction

  // Inputs are set at a falling edge; the output is checked at the next one.
  task automatic step(bit r, bit v, logic [3:0] d, logic [2:0] ld, logic [3:0] cv, string req);
    int cur;
    rst = r; digitValid = v; digitIn = d; loadCode = ld; codeIn = cv;
    @(posedge clk);
    cur = (expState < 3) ? expState : 0;
    expState = modelNext(expState, r, v, d, expCode[cur]);
    for (int i = 0; i < 3; i++) if (ld[i]) expCode[i] = cv;
    @(negedge clk);
    nChecks++;
    if (isOpen !== (expState == 3)) begin
      nFails++;
      $display("FAIL %s: isOpen actual=%0b expected=%0b", req, isOpen, (expState == 3));
    end
  endtask

  task automatic enter(logic [3:0] d, string req);
    step(0, 1, d, 3'b000, 4'h0, req);
  endtask

  initial begin
    rst = 1; digitValid = 0; digitIn = 0; loadCode = 0; codeIn = 0;
    for (int i = 0; i < 3; i++) expCode[i] = 4'h0;
    @(negedge clk);
    step(1, 0, 4'h0, 3'b000, 4'h0, "R1");
    step(1, 1, 4'h7, 3'b000, 4'h0, "R1");
    // R7: load each register through its own strobe
    step(0, 0, 4'h0, 3'b001, 4'h3, "R7");
    step(0, 0, 4'h0, 3'b010, 4'h9, "R7");
    step(0, 0, 4'h0, 3'b100, 4'h5, "R7");
    // R2 with R3 gaps, R9 closed until the end
    enter(4'h3, "R9");
    step(0, 0, 4'h9, 3'b000, 4'h0, "R3");
    step(0, 0, 4'h9, 3'b000, 4'h0, "R3");
    enter(4'h9, "R9");
    enter(4'h5, "R2");
    // R6: strobes while open
    enter(4'h1, "R6");
    enter(4'h3, "R6");
    // R1: reset beats a strobe; R7 code survives reset
    step(1, 1, 4'h3, 3'b000, 4'h0, "R1");
    enter(4'h3, "R7");
    enter(4'h9, "R7");
    enter(4'h5, "R7");
    // R4 mismatch at position 1, R5 fault absorbs a correct sequence
    step(1, 0, 4'h0, 3'b000, 4'h0, "R1");
    enter(4'h3, "R4");
    enter(4'h5, "R4");
    enter(4'h3, "R5");
    enter(4'h9, "R5");
    enter(4'h5, "R5");
    step(1, 0, 4'h0, 3'b000, 4'h0, "R5");
    enter(4'h3, "R5");
    enter(4'h9, "R5");
    enter(4'h5, "R5");
    // R8: digit of register 0 offered at position 1
    step(1, 0, 4'h0, 3'b000, 4'h0, "R1");
    enter(4'h3, "R8");
    enter(4'h3, "R8");
    enter(4'h9, "R8");
    enter(4'h5, "R8");
    // R8: third position against register 1 value
    step(1, 0, 4'h0, 3'b000, 4'h0, "R1");
    enter(4'h3, "R8");
    enter(4'h9, "R8");
    enter(4'h9, "R8");
    // Random phase
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      bit r, v;
      logic [3:0] d, cv;
      logic [2:0] ld;
      int pos;
      r  = ($urandom % 40) == 0;
      v  = ($urandom % 3) != 0;
      pos = (expState < 3) ? expState : 0;
      d  = (($urandom % 10) < 7) ? expCode[pos] : 4'($urandom);
      ld = (($urandom % 25) == 0) ? 3'(1 << ($urandom % 3)) : 3'b000;
      cv = 4'($urandom);
      step(r, v, d, ld, cv, "R9");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule